// File: doc/BRIEF.md
# Screen Tile Binner

The binner sits between geometry setup and per-tile fragment work. It accepts screen-space triangles, one per handshake, each carrying three signed integer pixel positions and a primitive pointer. A triangle that faces away from the viewer, or whose bounding box lies wholly off screen, is dropped at once. A surviving triangle has its bounding box clamped to the screen and converted to tile coordinates. Every tile inside that box is then visited, one per cycle, and the pointer is appended to that tile's list.

Lists live in two on-chip banks. One bank takes appends while the other, once frozen by an end-of-frame request, is offered for reading by the per-tile stage. The reader picks a tile and a slot and sees the stored pointer and the entry count for that tile. When the reader hands the bank back, it is free for the next swap. A list that is already full drops further appends and sets a sticky flag.

Top module: `tile_binner`

## Requirements
- R1: After reset, in_ready is 1, frame_done is 0, list_overflow is 0, and rd_count reads 0 for every tile.
- R2: With signed area A = (x1-x0)*(y2-y0) - (x2-x0)*(y1-y0), a triangle with A <= 0 is back-facing and dropped: no list changes, and in_ready is high again in the cycle after acceptance.
- R3: A triangle whose bounding box has max x < 0, min x > 127, max y < 0 or min y > 127 (screen of 128 by 128 pixels) is dropped in the same way.
- R4: For a kept triangle, each tile (tx, ty) with tx from clamp(min x)/16 to clamp(max x)/16 and ty from clamp(min y)/16 to clamp(max y)/16 receives the pointer once. Clamping is to the range 0..127. The tile index is ty*8+tx, and no other tile is changed.
- R5: Within one tile list, slot k holds the pointer of the k-th append of that frame, in acceptance order.
- R6: After a kept triangle covering N tiles is accepted, in_ready is low for exactly N cycles and then returns high.
- R7: Each list holds 16 entries. An append to a full list is dropped and its count stays 16. list_overflow then goes to 1 and holds until reset.
- R8: in_ready is 0 in any cycle where frame_end is 1. A frame_end seen while no triangle is being walked and frame_done is 0 freezes the current lists. frame_done is 1 from the next cycle, and rd_count and rd_ptr then show the frozen lists.
- R9: While frame_done is 1, new triangles go to the other bank and the frozen lists do not change. The bank that starts collecting after a swap begins with every count at 0.
- R10: frame_end is ignored while frame_done is 1. frame_release clears frame_done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| in_valid | input | 1 | triangle present |
| in_ready | output | 1 | triangle accepted when high with in_valid |
| in_x0 | input | COORD_W | vertex 0 x, signed pixels |
| in_y0 | input | COORD_W | vertex 0 y |
| in_x1 | input | COORD_W | vertex 1 x |
| in_y1 | input | COORD_W | vertex 1 y |
| in_x2 | input | COORD_W | vertex 2 x |
| in_y2 | input | COORD_W | vertex 2 y |
| in_ptr | input | PTR_W | primitive pointer |
| frame_end | input | 1 | end-of-frame request |
| frame_release | input | 1 | reader gives the frozen bank back |
| frame_done | output | 1 | a frozen bank is available |
| rd_tile | input | log2(tiles) | tile selected for reading |
| rd_slot | input | log2(LIST_DEPTH) | entry selected for reading |
| rd_ptr | output | PTR_W | pointer in the selected frozen entry |
| rd_count | output | log2(LIST_DEPTH+1) | entries in the selected frozen list |
| list_overflow | output | 1 | sticky dropped-append flag |

## Verification
The bench covers several culling edges. A degenerate triangle with zero area must be dropped; a design that tests strict sign only would bin it into four tiles. A triangle hanging off the left and bottom must be clamped; a design that skips clamping would write outside the grid or miss edge tiles. A full-screen triangle checks that the walker takes exactly 64 cycles in row-major order, and repeated appends to one tile check that the 17th entry is dropped rather than wrapping onto slot 0. Frame handling is driven through binning during a frozen frame, an ignored second frame_end and bank reuse; a design with a single bank or without count clearing would show altered or stale lists.

// File: rtl/tbin_pkg.sv
package tbin_pkg;
   localparam int unsigned TCOORD_W = 8;
   typedef logic [TCOORD_W-1:0] tcoord_t;

   typedef struct packed {
      tcoord_t tx_lo;
      tcoord_t tx_hi;
      tcoord_t ty_lo;
      tcoord_t ty_hi;
   } tile_box_t;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;
endpackage

// File: rtl/tbin_setup.sv
module tbin_setup
   import tbin_pkg::*;
#(
   parameter int COORD_W       = 12,
   parameter int TILE_SHIFT    = 4,
   parameter int TILES_X       = 8,
   parameter int TILES_Y       = 8,
   parameter bit FRONT_CCW     = 1'b1,
   parameter bit CULL_BACKFACE = 1'b1
) (
   input  logic [COORD_W-1:0] x0,
   input  logic [COORD_W-1:0] y0,
   input  logic [COORD_W-1:0] x1,
   input  logic [COORD_W-1:0] y1,
   input  logic [COORD_W-1:0] x2,
   input  logic [COORD_W-1:0] y2,
   output logic               cull,
   output tile_box_t          box
);
   localparam int EW = COORD_W + 1;
   localparam int DW = EW + 1;
   localparam int AW = 2 * DW + 1;
   localparam logic signed [EW-1:0] XLIM  = EW'((TILES_X << TILE_SHIFT) - 1);
   localparam logic signed [EW-1:0] YLIM  = EW'((TILES_Y << TILE_SHIFT) - 1);
   localparam logic signed [EW-1:0] EZERO = '0;
   localparam logic signed [AW-1:0] AZERO = '0;

   logic signed [EW-1:0] sx0, sy0, sx1, sy1, sx2, sy2;
   logic signed [DW-1:0] ax, ay, bx, by;
   logic signed [AW-1:0] p1, p2, area;
   logic signed [EW-1:0] minx, maxx, miny, maxy;
   logic signed [EW-1:0] cminx, cmaxx, cminy, cmaxy;
   logic back, outside;

   assign sx0 = EW'($signed(x0));
   assign sy0 = EW'($signed(y0));
   assign sx1 = EW'($signed(x1));
   assign sy1 = EW'($signed(y1));
   assign sx2 = EW'($signed(x2));
   assign sy2 = EW'($signed(y2));

   // edge vectors from vertex 0
   always_comb begin
      ax   = DW'(sx1) - DW'(sx0);
      ay   = DW'(sy1) - DW'(sy0);
      bx   = DW'(sx2) - DW'(sx0);
      by   = DW'(sy2) - DW'(sy0);
      p1   = ax * by;
      p2   = bx * ay;
      area = p1 - p2;
   end

   // winding variants
   generate
      if (!CULL_BACKFACE) begin : g_no_face
         assign back = 1'b0;
      end else if (FRONT_CCW) begin : g_ccw
         assign back = (area <= AZERO);
      end else begin : g_cw
         assign back = (area >= AZERO);
      end
   endgenerate

   // bounding box
   always_comb begin
      minx = sx0; maxx = sx0; miny = sy0; maxy = sy0;
      if (sx1 < minx) minx = sx1;
      if (sx2 < minx) minx = sx2;
      if (sx1 > maxx) maxx = sx1;
      if (sx2 > maxx) maxx = sx2;
      if (sy1 < miny) miny = sy1;
      if (sy2 < miny) miny = sy2;
      if (sy1 > maxy) maxy = sy1;
      if (sy2 > maxy) maxy = sy2;
   end

   assign outside = (maxx < EZERO) || (minx > XLIM) ||
                    (maxy < EZERO) || (miny > YLIM);
   assign cull    = back || outside;

   // clamp to screen, convert to tiles
   always_comb begin
      cminx = (minx < EZERO) ? EZERO : minx;
      cminy = (miny < EZERO) ? EZERO : miny;
      cmaxx = (maxx > XLIM)  ? XLIM  : maxx;
      cmaxy = (maxy > YLIM)  ? YLIM  : maxy;
      box.tx_lo = tcoord_t'(cminx >>> TILE_SHIFT);
      box.tx_hi = tcoord_t'(cmaxx >>> TILE_SHIFT);
      box.ty_lo = tcoord_t'(cminy >>> TILE_SHIFT);
      box.ty_hi = tcoord_t'(cmaxy >>> TILE_SHIFT);
   end
endmodule

// File: rtl/tbin_walker.sv
module tbin_walker
   import tbin_pkg::*;
#(
   parameter int TILES_X = 8,
   parameter int TILES_Y = 8,
   parameter int PTR_W   = 12,
   localparam int NTILES = TILES_X * TILES_Y,
   localparam int TIDX_W = $clog2(NTILES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  tile_box_t         box,
   input  logic [PTR_W-1:0]  ptr_in,
   output logic              busy,
   output logic              wr_en,
   output logic [TIDX_W-1:0] wr_tile,
   output logic [PTR_W-1:0]  wr_ptr
);
   walk_state_e state;
   tile_box_t   box_q;
   tcoord_t     cur_tx, cur_ty;
   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= WALK_IDLE;
         box_q  <= '0;
         cur_tx <= '0;
         cur_ty <= '0;
         ptr_q  <= '0;
      end else begin
         case (state)
            WALK_IDLE: begin
               if (start) begin
                  state  <= WALK_RUN;
                  box_q  <= box;
                  cur_tx <= box.tx_lo;
                  cur_ty <= box.ty_lo;
                  ptr_q  <= ptr_in;
               end
            end
            default: begin
               if (cur_tx == box_q.tx_hi) begin
                  if (cur_ty == box_q.ty_hi) begin
                     state <= WALK_IDLE;
                  end else begin
                     cur_tx <= box_q.tx_lo;
                     cur_ty <= cur_ty + 1'b1;
                  end
               end else begin
                  cur_tx <= cur_tx + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy    = (state == WALK_RUN);
   assign wr_en   = busy;
   assign wr_ptr  = ptr_q;
   assign wr_tile = TIDX_W'(int'(cur_ty) * TILES_X + int'(cur_tx));

   // R4
   walk_in_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cur_tx >= box_q.tx_lo && cur_tx <= box_q.tx_hi &&
                cur_ty >= box_q.ty_lo && cur_ty <= box_q.ty_hi &&
                int'(wr_tile) < NTILES));
endmodule

// File: rtl/tbin_lists.sv
module tbin_lists #(
   parameter int NTILES = 64,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = 12,
   localparam int TIDX_W = $clog2(NTILES),
   localparam int SLOT_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TIDX_W-1:0] wr_tile,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic              swap,
   input  logic              free_i,
   input  logic [TIDX_W-1:0] rd_tile,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              done,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [CNT_W-1:0]  rd_count,
   output logic              overflow
);
   logic [PTR_W-1:0] mem [2][NTILES][DEPTH];
   logic [CNT_W-1:0] cnt [2][NTILES];
   logic             wbank, rbank, done_q, ovf_q, room;
   logic [CNT_W-1:0] wr_cnt;

   assign rbank  = ~wbank;
   assign wr_cnt = cnt[wbank][wr_tile];
   assign room   = (wr_cnt < CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbank  <= 1'b0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
         for (int b = 0; b < 2; b++)
            for (int t = 0; t < NTILES; t++)
               cnt[b][t] <= '0;
      end else begin
         if (swap) begin
            wbank  <= rbank;
            done_q <= 1'b1;
            for (int t = 0; t < NTILES; t++)
               cnt[rbank][t] <= '0;
         end else if (free_i) begin
            done_q <= 1'b0;
         end
         if (wr_en) begin
            if (room) cnt[wbank][wr_tile] <= wr_cnt + 1'b1;
            else      ovf_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && room)
         mem[wbank][wr_tile][SLOT_W'(wr_cnt)] <= wr_ptr;
   end

   // read port variants: full index space or guarded
   generate
      if (NTILES == (1 << TIDX_W) && DEPTH == (1 << SLOT_W)) begin : g_rd_direct
         assign rd_count = cnt[rbank][rd_tile];
         assign rd_ptr   = mem[rbank][rd_tile][rd_slot];
      end else begin : g_rd_guard
         assign rd_count = (int'(rd_tile) < NTILES) ? cnt[rbank][rd_tile] : '0;
         assign rd_ptr   = (int'(rd_tile) < NTILES && int'(rd_slot) < DEPTH)
                           ? mem[rbank][rd_tile][rd_slot] : '0;
      end
   endgenerate

   assign done     = done_q;
   assign overflow = ovf_q;

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cnt == CNT_W'(DEPTH)) |=> (ovf_q && cnt[$past(wbank)][$past(wr_tile)] == CNT_W'(DEPTH)));

   // R9
   frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && $past(done_q) && $stable(rd_tile) && $stable(rd_slot)) |-> $stable(rd_count));

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !free_i) |=> done_q);
endmodule

// File: rtl/tile_binner.sv
module tile_binner
   import tbin_pkg::*;
#(
   parameter int COORD_W       = 12,
   parameter int PTR_W         = 12,
   parameter int TILE_SHIFT    = 4,
   parameter int TILES_X       = 8,
   parameter int TILES_Y       = 8,
   parameter int LIST_DEPTH    = 16,
   parameter bit FRONT_CCW     = 1'b1,
   parameter bit CULL_BACKFACE = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   output logic                                  in_ready,
   input  logic [COORD_W-1:0]                    in_x0,
   input  logic [COORD_W-1:0]                    in_y0,
   input  logic [COORD_W-1:0]                    in_x1,
   input  logic [COORD_W-1:0]                    in_y1,
   input  logic [COORD_W-1:0]                    in_x2,
   input  logic [COORD_W-1:0]                    in_y2,
   input  logic [PTR_W-1:0]                      in_ptr,
   input  logic                                  frame_end,
   input  logic                                  frame_release,
   output logic                                  frame_done,
   input  logic [$clog2(TILES_X*TILES_Y)-1:0]    rd_tile,
   input  logic [$clog2(LIST_DEPTH)-1:0]         rd_slot,
   output logic [PTR_W-1:0]                      rd_ptr,
   output logic [$clog2(LIST_DEPTH+1)-1:0]       rd_count,
   output logic                                  list_overflow
);
   localparam int NTILES = TILES_X * TILES_Y;
   localparam int TIDX_W = $clog2(NTILES);

   generate
      if (TILES_X < 2 || TILES_Y < 2) begin : g_bad_grid
         $error("tile grid needs at least 2 tiles per axis");
      end
      if (TILES_X > (1 << TCOORD_W) || TILES_Y > (1 << TCOORD_W)) begin : g_bad_tcoord
         $error("tile grid exceeds tile coordinate width");
      end
      if ((TILES_X << TILE_SHIFT) > (1 << (COORD_W - 1)) ||
          (TILES_Y << TILE_SHIFT) > (1 << (COORD_W - 1))) begin : g_bad_coord
         $error("COORD_W too small for the screen size");
      end
      if (LIST_DEPTH < 2 || PTR_W < 1) begin : g_bad_depth
         $error("LIST_DEPTH must be at least 2");
      end
   endgenerate

   logic      cull, walk_busy, wr_en, start, frame_take;
   tile_box_t box;
   logic [TIDX_W-1:0] wr_tile;
   logic [PTR_W-1:0]  wr_ptr;

   tbin_setup #(
      .COORD_W(COORD_W), .TILE_SHIFT(TILE_SHIFT),
      .TILES_X(TILES_X), .TILES_Y(TILES_Y),
      .FRONT_CCW(FRONT_CCW), .CULL_BACKFACE(CULL_BACKFACE)
   ) u_setup (
      .x0(in_x0), .y0(in_y0), .x1(in_x1), .y1(in_y1), .x2(in_x2), .y2(in_y2),
      .cull(cull), .box(box)
   );

   assign in_ready   = !walk_busy && !frame_end;
   assign start      = in_valid && in_ready && !cull;
   assign frame_take = frame_end && !walk_busy && !frame_done;

   tbin_walker #(
      .TILES_X(TILES_X), .TILES_Y(TILES_Y), .PTR_W(PTR_W)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .box(box), .ptr_in(in_ptr),
      .busy(walk_busy), .wr_en(wr_en), .wr_tile(wr_tile), .wr_ptr(wr_ptr)
   );

   tbin_lists #(
      .NTILES(NTILES), .DEPTH(LIST_DEPTH), .PTR_W(PTR_W)
   ) u_lists (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tile(wr_tile), .wr_ptr(wr_ptr),
      .swap(frame_take), .free_i(frame_release),
      .rd_tile(rd_tile), .rd_slot(rd_slot),
      .done(frame_done), .rd_ptr(rd_ptr), .rd_count(rd_count),
      .overflow(list_overflow)
   );

   // R6
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !cull) |=> !in_ready);

   // R2
   cull_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cull) |=> !wr_en);

   // R8
   frame_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !walk_busy && !frame_done) |=> frame_done);
endmodule

// File: tb/tile_binner_tb.sv
module tile_binner_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [11:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
   logic [11:0] in_ptr = '0;
   logic frame_end = 1'b0, frame_release = 1'b0, frame_done;
   logic [5:0] rd_tile = '0;
   logic [3:0] rd_slot = '0;
   logic [11:0] rd_ptr;
   logic [4:0] rd_count;
   logic list_overflow;

   int n_vec = 0;
   int n_bad = 0;
   int exp_q [2][64][$];
   int wb = 0;
   bit exp_done = 0;
   bit exp_ovf = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   tile_binner u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
      .in_x2(in_x2), .in_y2(in_y2), .in_ptr(in_ptr),
      .frame_end(frame_end), .frame_release(frame_release), .frame_done(frame_done),
      .rd_tile(rd_tile), .rd_slot(rd_slot), .rd_ptr(rd_ptr), .rd_count(rd_count),
      .list_overflow(list_overflow)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int mn3(int a, int b, int c);
      int m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      return m;
   endfunction

   function automatic int mx3(int a, int b, int c);
      int m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

   // driver: predicts lists (scoreboard) and walk length, then applies the triangle
   task automatic send_tri(int x0, int y0, int x1, int y1, int x2, int y2, int p, string req);
      int area, lx, hx, ly, hy, n, busy;
      bit cull;
      area = (x1 - x0) * (y2 - y0) - (x2 - x0) * (y1 - y0);
      lx = mn3(x0, x1, x2); hx = mx3(x0, x1, x2);
      ly = mn3(y0, y1, y2); hy = mx3(y0, y1, y2);
      cull = (area <= 0) || hx < 0 || lx > 127 || hy < 0 || ly > 127;
      n = 0;
      if (!cull) begin
         lx = (lx < 0 ? 0 : lx) / 16; hx = (hx > 127 ? 127 : hx) / 16;
         ly = (ly < 0 ? 0 : ly) / 16; hy = (hy > 127 ? 127 : hy) / 16;
         for (int ty = ly; ty <= hy; ty++)
            for (int tx = lx; tx <= hx; tx++) begin
               if (exp_q[wb][ty * 8 + tx].size() < 16) exp_q[wb][ty * 8 + tx].push_back(p);
               else exp_ovf = 1;
               n++;
            end
      end
      @(negedge clk);
      in_x0 = 12'(x0); in_y0 = 12'(y0); in_x1 = 12'(x1);
      in_y1 = 12'(y1); in_x2 = 12'(x2); in_y2 = 12'(y2);
      in_ptr = 12'(p); in_valid = 1'b1;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1 in_valid = 1'b0;
      busy = 0;
      @(negedge clk);
      while (!in_ready && busy < 200) begin busy++; @(negedge clk); end
      chk(busy == n, req, busy, n);
   endtask

   task automatic do_frame_end(string req);
      @(negedge clk);
      frame_end = 1'b1;
      #1 chk(in_ready == 1'b0, "R8", int'(in_ready), 0);
      @(posedge clk); #1 frame_end = 1'b0;
      if (!exp_done) begin exp_done = 1; wb = 1 - wb; end
      @(negedge clk);
      chk(frame_done == exp_done, req, int'(frame_done), int'(exp_done));
   endtask

   task automatic do_release();
      @(negedge clk); frame_release = 1'b1;
      @(posedge clk); #1 frame_release = 1'b0;
      exp_done = 0;
      @(negedge clk);
      chk(frame_done == 1'b0, "R10", int'(frame_done), 0);
   endtask

   // monitor: pops expected entries of the frozen bank and compares
   task automatic check_frame(int b);
      for (int t = 0; t < 64; t++) begin
         rd_tile = 6'(t); rd_slot = '0;
         #1 chk(int'(rd_count) == exp_q[b][t].size(), "R4", int'(rd_count), exp_q[b][t].size());
         for (int s = 0; exp_q[b][t].size() > 0; s++) begin
            int e;
            e = exp_q[b][t].pop_front();
            rd_slot = 4'(s);
            #1 chk(int'(rd_ptr) == e, "R5", int'(rd_ptr), e);
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
      chk(frame_done == 1'b0, "R1", int'(frame_done), 0);
      chk(list_overflow == 1'b0, "R1", int'(list_overflow), 0);
      rd_tile = 6'd0;  #1 chk(rd_count == 0, "R1", int'(rd_count), 0);
      rd_tile = 6'd63; #1 chk(rd_count == 0, "R1", int'(rd_count), 0);

      send_tri(0, 0, 20, 0, 0, 20, 11, "R6");          // 4 tiles
      send_tri(0, 0, 0, 20, 20, 0, 12, "R2");          // back-facing
      send_tri(0, 0, 10, 10, 20, 20, 13, "R2");        // zero area
      send_tri(-50, -50, -10, -50, -50, -10, 14, "R3"); // left/top off screen
      send_tri(130, 5, 200, 5, 130, 60, 15, "R3");     // right off screen
      send_tri(5, 140, 60, 140, 5, 190, 16, "R3");     // below screen
      send_tri(-30, 100, 200, 100, -30, 300, 17, "R4"); // clamped, 16 tiles
      send_tri(33, 33, 40, 33, 33, 40, 18, "R6");      // single tile 18
      send_tri(-100, -100, 300, -100, -100, 300, 19, "R6"); // all 64 tiles
      for (int i = 0; i < 16; i++)                     // R7: fill tile 18 past 16
         send_tri(34, 34, 44, 34, 34, 44, 100 + i, "R7");
      @(negedge clk);
      chk(list_overflow == exp_ovf, "R7", int'(list_overflow), int'(exp_ovf));

      do_frame_end("R8");                              // bank 0 frozen
      send_tri(70, 70, 90, 70, 70, 90, 200, "R9");     // goes to bank 1
      send_tri(0, 0, 15, 0, 0, 15, 201, "R9");
      do_frame_end("R10");                             // ignored, stays done
      check_frame(0);                                  // frozen lists unchanged
      do_release();
      chk(list_overflow == 1'b1, "R7", int'(list_overflow), 1);

      do_frame_end("R8");                              // bank 1 frozen
      check_frame(1);
      do_release();
      send_tri(120, 120, 127, 120, 120, 127, 300, "R9"); // into cleared bank 0
      do_frame_end("R9");
      check_frame(0);
      do_release();

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule